// File: doc/BRIEF.md
# Dual-Half Toggle and PWM Timer

This block is a 16-bit timer built from two 8-bit count stages, a low half and a high half, that drive two pins, `pin_lo` and `pin_hi`. A two-bit mode input decides how the halves are linked and what each pin shows. The halves can run as two separate toggle timers. They can run as two free-running 8-bit PWM channels. They can be chained into one 16-bit toggle timer. They can be chained into a 16-bit toggle timer whose low byte also produces a PWM waveform.

A toggle pin inverts each time its stage reaches its match value, so the pin's full period is twice the match interval. A PWM pin has a period of 256 counts. It is high while the count is below the latched duty value. The duty value is taken in only when the count returns to zero, so a write in the middle of a period never produces a stray pulse.

The counter that is able to count events can be switched from the clock to rising edges of `evt_in`. That is the high half in mode 0 and the whole 16-bit counter in mode 2. Each half raises a one-cycle flag when its count event occurs.

Top module: `pwtg_timer`

## Requirements
- R1: While `rst_n` or `en` is low, both pins and both flags are low, and enabling again restarts every count from zero.
- R2: In mode 0 (`mode`=2'b00), the low half counts every clock from 0 up to `match_lo` and then restarts. `pin_lo` inverts on each restart, so it changes every `match_lo`+1 clocks.
- R3: In mode 0, the high half behaves the same way against `match_hi`, independently of the low half. It advances on every clock when `ext_sel`=0, and only on each rising edge of `evt_in` when `ext_sel`=1.
- R4: In mode 1 (`mode`=2'b01), each half counts 0..255 freely. Its pin is high exactly while the count is below that half's latched duty (`duty_lo` or `duty_hi`), so the pin is high for duty clocks out of every 256. A duty of 0 keeps the pin low.
- R5: A PWM channel loads its duty input only in the clock where its count returns to 0, or while the channel is disabled. A duty change in mid-period does not affect the rest of that period.
- R6: In mode 2 (`mode`=2'b10), the halves form one 16-bit counter that restarts after reaching {`match_hi`,`match_lo`}. `pin_hi` inverts on each restart. `pin_lo` inverts whenever a count step starts from a low byte equal to `match_lo`.
- R7: In mode 3 (`mode`=2'b11), the 16-bit counter advances every clock and restarts after {`match_hi`,8'hFF}; `pin_hi` inverts on each restart. `pin_lo` is a PWM of the low byte against `duty_lo` (with the R4 and R5 rules), and the high byte moves only when the low byte wraps.
- R8: In mode 2 with `ext_sel`=1, the 16-bit counter advances only on rising edges of `evt_in`. In modes 1 and 3, `ext_sel` and `evt_in` have no effect.
- R9: `flag_lo` and `flag_hi` are high for one clock after their half's event. In modes 0 and 2 the event is a pin inversion. In mode 1 it is a count step out of 255. In mode 3 it is a low-byte wrap (for `flag_lo`) and a 16-bit restart (for `flag_hi`).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low clears counts and pins |
| mode | input | 2 | 0 split toggle, 1 dual PWM, 2 wide toggle, 3 wide toggle with low PWM |
| ext_sel | input | 1 | Count `evt_in` rising edges on the event-capable counter |
| evt_in | input | 1 | External event input, synchronous to `clk` |
| match_lo | input | 8 | Low-half match value |
| match_hi | input | 8 | High-half match value |
| duty_lo | input | 8 | Low PWM duty |
| duty_hi | input | 8 | High PWM duty |
| pin_lo | output | 1 | Low output pin |
| pin_hi | output | 1 | High output pin |
| flag_lo | output | 1 | Low-half event pulse |
| flag_hi | output | 1 | High-half event pulse |

## Verification
The assertions assume that `mode` and `ext_sel` change only while `en` is low, and that `evt_in` is already synchronous to `clk`. The mode and source stability is itself checked as an input property. The stimulus therefore drops `en` for at least one clock before each reconfiguration. It drives `evt_in` at the clock's falling edge and holds it for whole cycles, so every rising edge of `evt_in` is seen once. Duty values are rewritten only while a PWM channel is running, so that the boundary-latching rule is exercised without breaking the mode assumption.

// File: rtl/pwtg_pkg.sv
package pwtg_pkg;
  typedef enum logic [1:0] {
    MD_SPLIT_TOG = 2'd0,
    MD_DUAL_PWM  = 2'd1,
    MD_WIDE_TOG  = 2'd2,
    MD_WIDE_PWM  = 2'd3
  } tmr_mode_e;
endpackage

// File: rtl/pwtg_stage.sv
// One 8-bit (parameterised) count stage: advances on tick, clears on restart.
module pwtg_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         restart,
  input  logic [W-1:0] cmp,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_d,
  output logic         hit
);
  always_comb begin
    cnt_d = cnt;
    if (!run)
      cnt_d = '0;
    else if (tick)
      cnt_d = restart ? '0 : cnt + 1'b1;
  end

  assign hit = (cnt == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  // A restart taken on a tick must leave the stage at zero (R2).
  assert_restart_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && restart) |=> (cnt == '0))
    else $error("stage did not clear on restart");

  // A disabled stage sits at zero on the next clock (R1).
  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0))
    else $error("stage not cleared while idle");
endmodule

// File: rtl/pwtg_pwm.sv
// PWM slice: duty latched at the period boundary, output registered.
module pwtg_pwm #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         wrap,
  input  logic [W-1:0] duty,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cnt_d,
  output logic         pwm_o
);
  logic [W-1:0] duty_lat, duty_nx;
  logic         pwm_nx;

  always_comb begin
    duty_nx = duty_lat;
    if (!run || wrap)
      duty_nx = duty;
    pwm_nx = run && (cnt_d < duty_nx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_lat <= '0;
      pwm_o    <= 1'b0;
    end else begin
      duty_lat <= duty_nx;
      pwm_o    <= pwm_nx;
    end
  end

  // Zero duty never yields a high output (R4).
  assert_zero_duty_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_lat == '0) |-> !pwm_o)
    else $error("pwm high with zero duty");

  // Inside a running period the latched duty does not move (R5).
  assert_duty_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && cnt != '0) |-> $stable(duty_lat))
    else $error("duty latch changed mid-period");
endmodule

// File: rtl/pwtg_toggle.sv
// Toggle slice: inverts on each event, forced low while not running.
module pwtg_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic flip,
  output logic tog_o
);
  logic tog_nx;

  always_comb begin
    tog_nx = 1'b0;
    if (run)
      tog_nx = tog_o ^ flip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_o <= 1'b0;
    else        tog_o <= tog_nx;
  end

  // A running toggle output changes only after an event (R2).
  assert_flip_only_on_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && run && (tog_o != $past(tog_o))) |-> $past(flip))
    else $error("toggle moved without event");
endmodule

// File: rtl/pwtg_timer.sv
module pwtg_timer
  import pwtg_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [1:0]        mode,
  input  logic              ext_sel,
  input  logic              evt_in,
  input  logic [HALF_W-1:0] match_lo,
  input  logic [HALF_W-1:0] match_hi,
  input  logic [HALF_W-1:0] duty_lo,
  input  logic [HALF_W-1:0] duty_hi,
  output logic              pin_lo,
  output logic              pin_hi,
  output logic              flag_lo,
  output logic              flag_hi
);
  localparam int NH = 2;
  localparam logic [HALF_W-1:0] ALL1 = '1;

  tmr_mode_e md;
  assign md = tmr_mode_e'(mode);

  logic              evt_q, ext_tick, src_tick, lo_ff, full;
  logic              tick   [NH];
  logic              rstrt  [NH];
  logic [HALF_W-1:0] cmp    [NH];
  logic [HALF_W-1:0] cnt_q  [NH];
  logic [HALF_W-1:0] cnt_d  [NH];
  logic              hit    [NH];
  logic              ev     [NH];
  logic              pwm_sel[NH];
  logic              tog_sel[NH];
  logic [HALF_W-1:0] duty_in[NH];
  logic              pwm_q  [NH];
  logic              tog_q  [NH];
  logic              flag_q [NH];

  assign ext_tick   = evt_in & ~evt_q;
  assign src_tick   = ext_sel ? ext_tick : 1'b1;
  assign lo_ff      = (cnt_q[0] == ALL1);
  assign full       = hit[0] & hit[1];
  assign duty_in[0] = duty_lo;
  assign duty_in[1] = duty_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= 1'b0;
    else        evt_q <= evt_in;
  end

  // Per-mode linking of the two halves.
  always_comb begin
    tick[0] = 1'b1;  tick[1] = 1'b1;
    cmp[0]  = ALL1;  cmp[1]  = ALL1;
    rstrt[0] = hit[0]; rstrt[1] = hit[1];
    ev[0] = hit[0];  ev[1] = hit[1];
    pwm_sel[0] = 1'b0; pwm_sel[1] = 1'b0;
    tog_sel[0] = 1'b0; tog_sel[1] = 1'b0;
    unique case (md)
      MD_SPLIT_TOG: begin
        cmp[0] = match_lo;
        cmp[1] = match_hi;
        tick[1] = src_tick;
        ev[1] = src_tick & hit[1];
        tog_sel[0] = 1'b1; tog_sel[1] = 1'b1;
      end
      MD_DUAL_PWM: begin
        pwm_sel[0] = 1'b1; pwm_sel[1] = 1'b1;
      end
      MD_WIDE_TOG: begin
        cmp[0] = match_lo;
        cmp[1] = match_hi;
        tick[0] = src_tick;
        tick[1] = src_tick & (lo_ff | full);
        rstrt[0] = full;
        rstrt[1] = full;
        ev[0] = src_tick & hit[0];
        ev[1] = src_tick & full;
        tog_sel[0] = 1'b1; tog_sel[1] = 1'b1;
      end
      MD_WIDE_PWM: begin
        cmp[1] = match_hi;
        tick[1] = lo_ff;
        ev[0] = lo_ff;
        ev[1] = lo_ff & hit[1];
        pwm_sel[0] = 1'b1;
        tog_sel[1] = 1'b1;
      end
      default: ;
    endcase
  end

  for (genvar g = 0; g < NH; g++) begin : g_half
    pwtg_stage #(.W(HALF_W)) u_stage (
      .clk(clk), .rst_n(rst_n), .run(en), .tick(tick[g]),
      .restart(rstrt[g]), .cmp(cmp[g]),
      .cnt(cnt_q[g]), .cnt_d(cnt_d[g]), .hit(hit[g])
    );

    pwtg_pwm #(.W(HALF_W)) u_pwm (
      .clk(clk), .rst_n(rst_n), .run(en & pwm_sel[g]), .wrap(ev[g]),
      .duty(duty_in[g]), .cnt(cnt_q[g]), .cnt_d(cnt_d[g]), .pwm_o(pwm_q[g])
    );

    pwtg_toggle u_tog (
      .clk(clk), .rst_n(rst_n), .run(en & tog_sel[g]), .flip(ev[g]),
      .tog_o(tog_q[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[g] <= 1'b0;
      else        flag_q[g] <= en & ev[g];
    end
  end

  assign pin_lo  = pwm_sel[0] ? pwm_q[0] : tog_q[0];
  assign pin_hi  = pwm_sel[1] ? pwm_q[1] : tog_q[1];
  assign flag_lo = flag_q[0];
  assign flag_hi = flag_q[1];

  // Outputs are quiet one clock after the timer is disabled (R1).
  assert_quiet_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> (!pin_lo && !pin_hi && !flag_lo && !flag_hi))
    else $error("outputs active while disabled");

  // Input assumption: configuration only changes while disabled (R1).
  assert_cfg_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> ($stable(mode) && $stable(ext_sel)))
    else $error("mode changed while running");

  // PWM period flags are isolated single pulses (R9).
  assert_pwm_flag_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && md == MD_DUAL_PWM && $past(flag_lo)) |-> !flag_lo)
    else $error("back-to-back pwm flags");

  // In mode 3 the high byte only moves on a low-byte wrap (R7).
  assert_hi_follows_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && md == MD_WIDE_PWM && cnt_q[0] != '0) |-> $stable(cnt_q[1]))
    else $error("high byte moved without wrap");
endmodule

// File: tb/pwtg_timer_test.sv
`timescale 1ns/1ps
module pwtg_timer_test;
  logic       clk = 1'b0;
  logic       rst_n, en, ext_sel, evt_in;
  logic [1:0] mode;
  logic [7:0] match_lo, match_hi, duty_lo, duty_hi;
  logic       pin_lo, pin_hi, flag_lo, flag_hi;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  pwtg_timer uut (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .ext_sel(ext_sel),
    .evt_in(evt_in), .match_lo(match_lo), .match_hi(match_hi),
    .duty_lo(duty_lo), .duty_hi(duty_hi),
    .pin_lo(pin_lo), .pin_hi(pin_hi), .flag_lo(flag_lo), .flag_hi(flag_hi)
  );

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model, updated at every rising edge.
  int m_clo, m_chi, m_c16, m_dl, m_dh;
  bit m_tl, m_th, m_pl, m_ph, m_flo, m_fhi, m_evq;

  always @(posedge clk) begin
    bit etk, src;
    bit elo, ehi;
    string tag;
    if (!rst_n) begin
      m_clo = 0; m_chi = 0; m_c16 = 0; m_dl = 0; m_dh = 0;
      m_tl = 0; m_th = 0; m_pl = 0; m_ph = 0; m_flo = 0; m_fhi = 0; m_evq = 0;
    end else begin
      etk = evt_in && !m_evq;
      m_evq = evt_in;
      src = ext_sel ? etk : 1'b1;
      m_flo = 0; m_fhi = 0;
      if (!en) begin
        m_clo = 0; m_chi = 0; m_c16 = 0;
        m_tl = 0; m_th = 0; m_pl = 0; m_ph = 0;
        m_dl = duty_lo; m_dh = duty_hi;
      end else begin
        case (mode)
          2'd0: begin
            if (m_clo == match_lo) begin m_clo = 0; m_tl ^= 1; m_flo = 1; end
            else m_clo++;
            if (src) begin
              if (m_chi == match_hi) begin m_chi = 0; m_th ^= 1; m_fhi = 1; end
              else m_chi++;
            end
          end
          2'd1: begin
            m_flo = (m_clo == 255); m_clo = (m_clo + 1) % 256;
            if (m_clo == 0) m_dl = duty_lo;
            m_pl = (m_clo < m_dl);
            m_fhi = (m_chi == 255); m_chi = (m_chi + 1) % 256;
            if (m_chi == 0) m_dh = duty_hi;
            m_ph = (m_chi < m_dh);
          end
          2'd2: begin
            if (src) begin
              if ((m_c16 % 256) == match_lo) begin m_tl ^= 1; m_flo = 1; end
              if (m_c16 == match_hi * 256 + match_lo) begin m_c16 = 0; m_th ^= 1; m_fhi = 1; end
              else m_c16++;
            end
          end
          default: begin
            if ((m_c16 % 256) == 255) m_flo = 1;
            if (m_c16 == match_hi * 256 + 255) begin m_c16 = 0; m_th ^= 1; m_fhi = 1; end
            else m_c16++;
            if ((m_c16 % 256) == 0) m_dl = duty_lo;
            m_pl = ((m_c16 % 256) < m_dl);
          end
        endcase
      end
    end
    #1;
    if (!rst_n || !en) tag = "R1";
    else case (mode)
      2'd0: tag = "R2";
      2'd1: tag = "R4";
      2'd2: tag = "R6";
      default: tag = "R7";
    endcase
    elo = (mode == 2'd1 || mode == 2'd3) ? m_pl : m_tl;
    ehi = (mode == 2'd1) ? m_ph : m_th;
    check({tag, " pin_lo"}, pin_lo, elo);
    check({tag, " pin_hi"}, pin_hi, ehi);
    check({"R9 flag_lo ", tag}, flag_lo, m_flo);
    check({"R9 flag_hi ", tag}, flag_hi, m_fhi);
  end

  // Observe n clocks; optionally drive an event every third clock (48 events).
  task automatic run_win(input int n, input bit drive_evt,
                         output int tlo, output int thi, output int hlo,
                         output int hhi, output int flo, output int fhi);
    bit plo = pin_lo, phi = pin_hi;
    tlo = 0; thi = 0; hlo = 0; hhi = 0; flo = 0; fhi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pin_lo != plo) tlo++;
      if (pin_hi != phi) thi++;
      plo = pin_lo; phi = pin_hi;
      hlo += pin_lo; hhi += pin_hi; flo += flag_lo; fhi += flag_hi;
      if (drive_evt) evt_in = (i < 144) && (i % 3 == 0);
    end
    evt_in = 1'b0;
  endtask

  task automatic stop_timer();
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    check("R1 pin_lo after disable", pin_lo, 0);
    check("R1 pin_hi after disable", pin_hi, 0);
  endtask

  initial begin
    int tlo, thi, hlo, hhi, flo, fhi;
    rst_n = 1'b0; en = 1'b0; mode = 2'd0; ext_sel = 1'b0; evt_in = 1'b0;
    match_lo = 8'd0; match_hi = 8'd0; duty_lo = 8'd0; duty_hi = 8'd0;
    repeat (4) @(negedge clk);
    check("R1 reset pin_lo", pin_lo, 0);
    check("R1 reset flag_hi", flag_hi, 0);
    rst_n = 1'b1;

    // Mode 0, both halves on the clock.
    match_lo = 8'd5; match_hi = 8'd9;
    @(negedge clk); en = 1'b1;
    run_win(120, 0, tlo, thi, hlo, hhi, flo, fhi);
    check("R2 low toggles", tlo, 20);
    check("R3 high toggles on clock", thi, 12);
    check("R9 low flags", flo, 20);
    stop_timer();

    // Mode 0, high half on external events.
    match_lo = 8'd7; match_hi = 8'd3; ext_sel = 1'b1;
    @(negedge clk); en = 1'b1;
    run_win(150, 1, tlo, thi, hlo, hhi, flo, fhi);
    check("R3 high toggles on events", thi, 12);
    check("R2 low independent of events", tlo, 18);
    stop_timer();

    // Mode 1, dual PWM.
    ext_sel = 1'b0; mode = 2'd1; duty_lo = 8'd64; duty_hi = 8'd0;
    @(negedge clk); en = 1'b1;
    run_win(512, 0, tlo, thi, hlo, hhi, flo, fhi);
    check("R4 low duty high count", hlo, 128);
    check("R4 zero duty stays low", hhi, 0);
    check("R9 pwm period flags", flo, 2);
    run_win(100, 0, tlo, thi, hlo, hhi, flo, fhi);
    check("R4 partial period", hlo, 63);
    duty_lo = 8'd200;
    run_win(156, 0, tlo, thi, hlo, hhi, flo, fhi);
    check("R5 old duty kept mid-period", hlo, 1);
    run_win(256, 0, tlo, thi, hlo, hhi, flo, fhi);
    check("R5 new duty after boundary", hlo, 200);
    stop_timer();

    // Mode 2, 16-bit toggle on the clock.
    mode = 2'd2; match_lo = 8'd3; match_hi = 8'd1;
    @(negedge clk); en = 1'b1;
    run_win(1040, 0, tlo, thi, hlo, hhi, flo, fhi);
    check("R6 wide high toggles", thi, 4);
    check("R6 low byte toggles", tlo, 8);
    stop_timer();

    // Mode 2 on external events.
    match_lo = 8'd1; match_hi = 8'd0; ext_sel = 1'b1;
    @(negedge clk); en = 1'b1;
    run_win(150, 1, tlo, thi, hlo, hhi, flo, fhi);
    check("R8 wide toggles on events", thi, 24);
    check("R8 low toggles on events", tlo, 24);
    stop_timer();

    // Mode 3 with ext_sel set but no events: the source select is ignored.
    mode = 2'd3; match_hi = 8'd2; duty_lo = 8'd100;
    @(negedge clk); en = 1'b1;
    run_win(1600, 0, tlo, thi, hlo, hhi, flo, fhi);
    check("R7 wide toggles", thi, 2);
    check("R7 low pwm high count", hlo, 664);
    check("R7 low wrap flags", flo, 6);
    check("R8 ext_sel ignored in mode 3", fhi, 2);
    stop_timer();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(150000 * 5);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule